// File: doc/BRIEF.md
# Compact 16-bit Instruction Decoder

This block turns one 16-bit instruction word of a small load/store machine into the controls the rest of the datapath needs. The machine has sixteen registers, and each instruction has a single 4-bit opcode in the top nibble. The lower twelve bits are split into three 4-bit register or constant fields, except for the linking jump, which uses all twelve bits as a target. The decoder does not contain the register file, the ALU, the memory or the program-counter logic.

Every output is registered. The fields and controls for an instruction appear on the clock edge after the word is sampled. The register-read indices always come from fixed bit positions, so a register file can start its reads straight from the pipeline register. Class flags tell the consumer which of the other outputs are meaningful. Outputs that do not apply to the current class are forced to zero.

Top module: `cdec16`

## Requirements
- R1: The reset is synchronous and active high. While it is sampled high, every output is zero on the following edge, whatever the instruction input is.
- R2: When reset is low, the outputs after a rising edge describe the instruction word sampled at that edge. The latency is exactly one cycle.
- R3: Exactly one class flag is high after any decoded instruction. Opcodes 0 to 4 raise the R-type flag, 5 to 8 the immediate-type flag, 9 load, A store, B branch-if-equal, C branch-if-not-equal, D shift, E jump-and-link and F jump-register.
- R4: The ALU select follows this encoding: 0 add, 1 subtract, 2 and, 3 or, 4 set-less-than. Opcodes 0 to 4 map to selects 0 to 4 in that order. Opcodes 5/6/7/8 map to 0/2/3/4. Opcodes B and C map to 1. Every other opcode maps to 0.
- R5: The first read index is always bits 3:0 and the second read index is always bits 7:4.
- R6: The 16-bit constant is bits 11:8 sign-extended (bit 11 copied upward) for opcodes 5, 8, 9, A, B and C. It is zero-extended for opcodes 6 and 7. It is zero for all other opcodes.
- R7: Write enable is high for opcodes 0 to 9, D and E, and low otherwise. The write index is bits 11:8 for opcodes 0 to 4, bits 7:4 for opcodes 5 to 9 and D, 15 for opcode E, and 0 when write enable is low.
- R8: The jump target equals bits 11:0 for opcode E and is zero otherwise.
- R9: The shift-type code equals bits 11:8 for opcode D and is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 16 | Instruction word |
| rd_a_o | output | 4 | First register-read index (bits 3:0) |
| rd_b_o | output | 4 | Second register-read index (bits 7:4) |
| wr_en_o | output | 1 | Register write enable |
| wr_idx_o | output | 4 | Register write index |
| imm_o | output | 16 | Extended immediate or offset |
| jtarget_o | output | 12 | Jump-and-link target |
| alu_op_o | output | 3 | ALU operation select |
| shift_type_o | output | 4 | Shift-type code |
| is_load_o | output | 1 | Load class |
| is_store_o | output | 1 | Store class |
| is_beq_o | output | 1 | Branch-if-equal class |
| is_bne_o | output | 1 | Branch-if-not-equal class |
| is_rtype_o | output | 1 | Register-register ALU class |
| is_itype_o | output | 1 | Register-immediate ALU class |
| is_shift_o | output | 1 | Shift class |
| is_jal_o | output | 1 | Jump-and-link class |
| is_jr_o | output | 1 | Jump-register class |

## Verification
The hardest cases to reach are the ones where bits 11:8 carry a value with the top bit set under an opcode that must not use it. The bench has to show that this value never leaks into the constant, the shift code, the target or the write index. The stimulus therefore sweeps all sixteen opcodes with upper-field values 0, 7, 8 and F, so that sign-extended, zero-extended and suppressed forms all occur. Pseudo-random words then fill in the mixed fields. A reset is also asserted while a jump-and-link word is held on the input, to show that reset wins over a live instruction.

// File: rtl/cdec_pkg.sv
package cdec_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'h0, OP_SUB  = 4'h1, OP_AND  = 4'h2, OP_OR   = 4'h3,
    OP_SLT  = 4'h4, OP_ADDI = 4'h5, OP_ANDI = 4'h6, OP_ORI  = 4'h7,
    OP_SLTI = 4'h8, OP_LW   = 4'h9, OP_SW   = 4'hA, OP_BEQ  = 4'hB,
    OP_BNE  = 4'hC, OP_SHF  = 4'hD, OP_JAL  = 4'hE, OP_JR   = 4'hF
  } opcode_e;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0, ALU_SUB = 3'd1, ALU_AND = 3'd2, ALU_OR = 3'd3, ALU_SLT = 3'd4
  } alu_sel_e;

  typedef struct packed {
    logic load;
    logic store;
    logic beq;
    logic bne;
    logic rtype;
    logic itype;
    logic shift;
    logic jal;
    logic jr;
  } cls_t;

  typedef enum logic [1:0] {
    EXT_NONE = 2'd0, EXT_SIGN = 2'd1, EXT_ZERO = 2'd2
  } ext_e;
endpackage

// File: rtl/cdec_class.sv
module cdec_class
  import cdec_pkg::*;
(
  input  opcode_e  op_i,
  output cls_t     cls_o,
  output alu_sel_e alu_o,
  output ext_e     ext_o
);
  always_comb begin
    cls_o = '0;
    alu_o = ALU_ADD;
    ext_o = EXT_NONE;
    unique case (op_i)
      OP_ADD:  begin cls_o.rtype = 1'b1; alu_o = ALU_ADD; end
      OP_SUB:  begin cls_o.rtype = 1'b1; alu_o = ALU_SUB; end
      OP_AND:  begin cls_o.rtype = 1'b1; alu_o = ALU_AND; end
      OP_OR:   begin cls_o.rtype = 1'b1; alu_o = ALU_OR;  end
      OP_SLT:  begin cls_o.rtype = 1'b1; alu_o = ALU_SLT; end
      OP_ADDI: begin cls_o.itype = 1'b1; alu_o = ALU_ADD; ext_o = EXT_SIGN; end
      OP_ANDI: begin cls_o.itype = 1'b1; alu_o = ALU_AND; ext_o = EXT_ZERO; end
      OP_ORI:  begin cls_o.itype = 1'b1; alu_o = ALU_OR;  ext_o = EXT_ZERO; end
      OP_SLTI: begin cls_o.itype = 1'b1; alu_o = ALU_SLT; ext_o = EXT_SIGN; end
      OP_LW:   begin cls_o.load  = 1'b1; ext_o = EXT_SIGN; end
      OP_SW:   begin cls_o.store = 1'b1; ext_o = EXT_SIGN; end
      OP_BEQ:  begin cls_o.beq   = 1'b1; alu_o = ALU_SUB; ext_o = EXT_SIGN; end
      OP_BNE:  begin cls_o.bne   = 1'b1; alu_o = ALU_SUB; ext_o = EXT_SIGN; end
      OP_SHF:  cls_o.shift = 1'b1;
      OP_JAL:  cls_o.jal   = 1'b1;
      OP_JR:   cls_o.jr    = 1'b1;
      default: cls_o = '0;
    endcase
  end
endmodule

// File: rtl/cdec_imm.sv
module cdec_imm
  import cdec_pkg::*;
#(
  parameter int FW = 4,
  parameter int DW = 16
) (
  input  logic [FW-1:0] fld_i,
  input  ext_e          ext_i,
  output logic [DW-1:0] imm_o
);
  localparam int PADW = DW - FW;

  logic [PADW-1:0] pad;

  always_comb begin
    pad = '0;
    if (ext_i == EXT_SIGN) pad = {PADW{fld_i[FW-1]}};
    if (ext_i == EXT_NONE) imm_o = '0;
    else                   imm_o = {pad, fld_i};
  end
endmodule

// File: rtl/cdec_wr.sv
module cdec_wr
  import cdec_pkg::*;
#(
  parameter int RW   = 4,
  parameter int LINK = 15
) (
  input  cls_t          cls_i,
  input  logic [RW-1:0] hi_i,
  input  logic [RW-1:0] mid_i,
  output logic          we_o,
  output logic [RW-1:0] idx_o
);
  always_comb begin
    we_o  = 1'b0;
    idx_o = '0;
    if (cls_i.rtype) begin
      we_o  = 1'b1;
      idx_o = hi_i;
    end else if (cls_i.itype || cls_i.load || cls_i.shift) begin
      we_o  = 1'b1;
      idx_o = mid_i;
    end else if (cls_i.jal) begin
      we_o  = 1'b1;
      idx_o = RW'(LINK);
    end
  end
endmodule

// File: rtl/cdec16.sv
module cdec16
  import cdec_pkg::*;
#(
  parameter int RW   = 4,
  parameter int DW   = 16,
  parameter int LINK = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [15:0]   instr_i,
  output logic [RW-1:0] rd_a_o,
  output logic [RW-1:0] rd_b_o,
  output logic          wr_en_o,
  output logic [RW-1:0] wr_idx_o,
  output logic [DW-1:0] imm_o,
  output logic [11:0]   jtarget_o,
  output logic [2:0]    alu_op_o,
  output logic [RW-1:0] shift_type_o,
  output logic          is_load_o,
  output logic          is_store_o,
  output logic          is_beq_o,
  output logic          is_bne_o,
  output logic          is_rtype_o,
  output logic          is_itype_o,
  output logic          is_shift_o,
  output logic          is_jal_o,
  output logic          is_jr_o
);
  localparam int IW   = 16;
  localparam int OPW  = IW - 3 * RW;
  localparam int JW   = IW - OPW;
  localparam int F1LO = 0;
  localparam int F2LO = RW;
  localparam int F3LO = 2 * RW;

  opcode_e       op_w;
  cls_t          cls_w;
  alu_sel_e      alu_w;
  ext_e          ext_w;
  logic [DW-1:0] imm_w;
  logic          we_w;
  logic [RW-1:0] idx_w;
  logic [RW-1:0] f1, f2, f3;

  assign op_w = opcode_e'(instr_i[IW-1 -: OPW]);
  assign f1   = instr_i[F1LO +: RW];
  assign f2   = instr_i[F2LO +: RW];
  assign f3   = instr_i[F3LO +: RW];

  cdec_class u_cls (.op_i(op_w), .cls_o(cls_w), .alu_o(alu_w), .ext_o(ext_w));

  cdec_imm #(.FW(RW), .DW(DW)) u_imm (.fld_i(f3), .ext_i(ext_w), .imm_o(imm_w));

  cdec_wr #(.RW(RW), .LINK(LINK)) u_wr (
    .cls_i(cls_w), .hi_i(f3), .mid_i(f2), .we_o(we_w), .idx_o(idx_w)
  );

  cls_t cls_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_a_o       <= '0;
      rd_b_o       <= '0;
      wr_en_o      <= 1'b0;
      wr_idx_o     <= '0;
      imm_o        <= '0;
      jtarget_o    <= '0;
      alu_op_o     <= '0;
      shift_type_o <= '0;
      cls_q        <= '0;
    end else begin
      rd_a_o       <= f1;
      rd_b_o       <= f2;
      wr_en_o      <= we_w;
      wr_idx_o     <= idx_w;
      imm_o        <= imm_w;
      jtarget_o    <= cls_w.jal ? instr_i[JW-1:0] : '0;
      alu_op_o     <= alu_w;
      shift_type_o <= cls_w.shift ? f3 : '0;
      cls_q        <= cls_w;
    end
  end

  assign is_load_o  = cls_q.load;
  assign is_store_o = cls_q.store;
  assign is_beq_o   = cls_q.beq;
  assign is_bne_o   = cls_q.bne;
  assign is_rtype_o = cls_q.rtype;
  assign is_itype_o = cls_q.itype;
  assign is_shift_o = cls_q.shift;
  assign is_jal_o   = cls_q.jal;
  assign is_jr_o    = cls_q.jr;

  p_onehot_class_r3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $countones(cls_q) == 1);

  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (rd_a_o == $past(instr_i[3:0]) && rd_b_o == $past(instr_i[7:4])));

  p_link_r7: assert property (@(posedge clk) disable iff (rst)
    is_jal_o |-> (wr_en_o && wr_idx_o == RW'(LINK)));

  p_idx_zero_r7: assert property (@(posedge clk) disable iff (rst)
    !wr_en_o |-> wr_idx_o == '0);

  p_target_zero_r8: assert property (@(posedge clk) disable iff (rst)
    !is_jal_o |-> jtarget_o == '0);

  p_shift_zero_r9: assert property (@(posedge clk) disable iff (rst)
    !is_shift_o |-> shift_type_o == '0);

  p_branch_sub_r4: assert property (@(posedge clk) disable iff (rst)
    (is_beq_o || is_bne_o) |-> alu_op_o == 3'd1);
endmodule

// File: tb/sim_cdec16.sv
module sim_cdec16;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] instr = 16'h0000;
  logic [3:0]  rd_a, rd_b, wr_idx, sht;
  logic        wr_en;
  logic [15:0] imm;
  logic [11:0] jt;
  logic [2:0]  alu;
  logic        f_ld, f_st, f_beq, f_bne, f_r, f_i, f_sh, f_jal, f_jr;

  int n_run  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  cdec16 u0 (
    .clk(clk), .rst(rst), .instr_i(instr),
    .rd_a_o(rd_a), .rd_b_o(rd_b), .wr_en_o(wr_en), .wr_idx_o(wr_idx),
    .imm_o(imm), .jtarget_o(jt), .alu_op_o(alu), .shift_type_o(sht),
    .is_load_o(f_ld), .is_store_o(f_st), .is_beq_o(f_beq), .is_bne_o(f_bne),
    .is_rtype_o(f_r), .is_itype_o(f_i), .is_shift_o(f_sh), .is_jal_o(f_jal),
    .is_jr_o(f_jr)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (instr=%04h)", req, act, exp, instr);
    end
  endtask

  function automatic int act_flags();
    return {f_ld, f_st, f_beq, f_bne, f_r, f_i, f_sh, f_jal, f_jr};
  endfunction

  // behavioural expectation for one word
  task automatic check_word(input logic [15:0] w);
    int op, hi, mid, lo, e_fl, e_alu, e_imm, e_we, e_idx, e_jt, e_sh;
    op = int'(w[15:12]); hi = int'(w[11:8]); mid = int'(w[7:4]); lo = int'(w[3:0]);
    if (op <= 4)       e_fl = 9'b000010000;
    else if (op <= 8)  e_fl = 9'b000001000;
    else if (op == 9)  e_fl = 9'b100000000;
    else if (op == 10) e_fl = 9'b010000000;
    else if (op == 11) e_fl = 9'b001000000;
    else if (op == 12) e_fl = 9'b000100000;
    else if (op == 13) e_fl = 9'b000000100;
    else if (op == 14) e_fl = 9'b000000010;
    else               e_fl = 9'b000000001;
    case (op)
      0, 5: e_alu = 0;
      1, 11, 12: e_alu = 1;
      2, 6: e_alu = 2;
      3, 7: e_alu = 3;
      4, 8: e_alu = 4;
      default: e_alu = 0;
    endcase
    if (op == 5 || op == 8 || (op >= 9 && op <= 12))
      e_imm = (hi >= 8) ? (hi + 16'hFFF0) : hi;
    else if (op == 6 || op == 7) e_imm = hi;
    else e_imm = 0;
    e_we  = (op <= 9 || op == 13 || op == 14) ? 1 : 0;
    if (op <= 4) e_idx = hi;
    else if (op <= 9 || op == 13) e_idx = mid;
    else if (op == 14) e_idx = 15;
    else e_idx = 0;
    e_jt = (op == 14) ? int'(w[11:0]) : 0;
    e_sh = (op == 13) ? hi : 0;
    chk("R3 class flags", act_flags(), e_fl);
    chk("R4 alu select", int'(alu), e_alu);
    chk("R5 read index a", int'(rd_a), lo);
    chk("R5 read index b", int'(rd_b), mid);
    chk("R6 immediate", int'(imm), e_imm);
    chk("R7 write enable", int'(wr_en), e_we);
    chk("R7 write index", int'(wr_idx), e_idx);
    chk("R8 jump target", int'(jt), e_jt);
    chk("R9 shift type", int'(sht), e_sh);
  endtask

  // drive at a falling edge, check at the next one (one rising edge between: R2)
  task automatic apply(input logic [15:0] w);
    instr = w;
    @(negedge clk);
    check_word(w);
  endtask

  task automatic check_reset_state();
    chk("R1 flags zero", act_flags(), 0);
    chk("R1 read idx zero", int'({rd_a, rd_b}), 0);
    chk("R1 write zero", int'({wr_en, wr_idx}), 0);
    chk("R1 imm zero", int'(imm), 0);
    chk("R1 target/shift/alu zero", int'({jt, sht, alu}), 0);
  endtask

  initial begin
    #1600000;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    repeat (3) @(negedge clk);
    instr = 16'hE5A3;
    @(negedge clk);
    check_reset_state();
    rst = 1'b0;
    // R2 latency: a word followed by a different one, each seen one cycle later
    apply(16'h0123);
    apply(16'hF0C7);
    // sweep of every opcode against boundary upper-field values
    for (int op = 0; op < 16; op++) begin
      for (int k = 0; k < 4; k++) begin
        logic [3:0] hv;
        hv = (k == 0) ? 4'h0 : (k == 1) ? 4'h7 : (k == 2) ? 4'h8 : 4'hF;
        apply({op[3:0], hv, 4'(op + k), 4'(15 - op)});
      end
    end
    // pseudo-random words
    lf = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      apply(lf);
    end
    // R1: reset wins over a live jump-and-link word
    instr = 16'hEFFF;
    rst = 1'b1;
    @(negedge clk);
    check_reset_state();
    rst = 1'b0;
    apply(16'hEFFF);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule